// File: doc/BRIEF.md
# Program-ROM Bank Mapper with Work-RAM Gating

This block sits between a CPU's 16-bit address bus and a program ROM that is larger than the CPU can see. The upper half of the CPU map, 0x8000 to 0xFFFF, is cut into four 8 KB windows. CPU address bits 14:13 pick the window. Each window is given a 6-bit bank number, and the ROM address is that bank number placed above CPU address bits 12:0. Two windows follow software-loaded bank registers. The last window always shows the final bank. The remaining window shows the second-to-last bank, and a mode bit moves it between the first and third window positions.

The mode bit acts as a two-state machine. In `MODE_LOW`, window 0 is switchable and window 2 is fixed. In `MODE_HIGH`, window 0 is fixed and window 2 is switchable. The only transition between the two states is a write to the select register, which moves to `MODE_HIGH` when data bit 6 is 1 and to `MODE_LOW` when it is 0. Reset enters `MODE_LOW`. The same block also gates the 8 KB work RAM at 0x6000–0x7FFF. That RAM can be enabled, disabled, or left readable with writes blocked. The RAM enables and the ROM address are combinational from the CPU address and the registered state.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the mapper is in `MODE_LOW`, the select field and both bank registers are 0, the RAM is enabled and writes to it are allowed. Reading 0x8000 therefore maps to ROM 0x00000, 0xC000 maps to 0x7C000 and 0xE000 maps to 0x7E000.
- R2: The ROM address is {bank[5:0], cpu_addr[12:0]}, a 19-bit value. The bank comes from the window selected by cpu_addr[14:13].
- R3: In `MODE_LOW`, window 0 uses bank register A and window 2 uses fixed bank 0x3E.
- R4: In `MODE_HIGH`, window 0 uses fixed bank 0x3E and window 2 uses bank register A.
- R5: Window 1 always uses bank register B, and window 3 always uses fixed bank 0x3F, in both modes.
- R6: A write whose address ANDed with 0xE001 equals 0x8000 is a select write. It loads the mode from data bit 6 and the 3-bit select field from data bits 2:0. Mirror addresses such as 0x9FFE decode the same way.
- R7: A write whose address ANDed with 0xE001 equals 0x8001 is a bank-data write. With select 6 it loads bank register A, and with select 7 it loads bank register B, in both cases with data bits 5:0. With select 0 to 5 it leaves both bank registers unchanged.
- R8: A write whose address ANDed with 0xE001 equals 0xA001 is a RAM-control write. It loads RAM enable from data bit 7 and write protect from data bit 6.
- R9: ram_rd_en is 1 exactly when cpu_addr[15:13] = 3'b011 and the RAM is enabled. ram_addr equals cpu_addr[12:0].
- R10: ram_wr_en is 1 exactly when cpu_wr is 1, the address is in 0x6000–0x7FFF, the RAM is enabled and write protect is 0.
- R11: Writes to any other decoded address (such as 0xA000, 0xC001 or 0xE000), writes into the RAM range, and cycles with cpu_wr low change none of the mapper state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes take effect at its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| rom_addr | output | 19 | Translated program-ROM address |
| ram_addr | output | 13 | Work-RAM address |
| ram_rd_en | output | 1 | Work-RAM read enable; when it is 0 the read returns 0x00 |
| ram_wr_en | output | 1 | Work-RAM write enable |

## Verification
The bench loads 0xFF into a bank register to show the 6-bit mask. A design that stored the full byte would put ones above bit 18 of the bank field and drive a wrong ROM address. It switches the mode through a mirror address: a design that decoded all 16 address bits would ignore that write and stay in `MODE_LOW`. It writes bank data while a character-bank select is active, so a design that wrote a program register for any select value would show a changed window. The RAM is walked through its enabled, protected and disabled settings, and writes are tried at 0xA000, 0xC001, 0xE000 and with the strobe low. A design that confused the two control bits, or that decoded on A0 alone, would raise the wrong RAM enable or move a window.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;

    // Mapping mode: which of windows 0 and 2 holds the switchable bank
    typedef enum logic {
        MODE_LOW  = 1'b0,
        MODE_HIGH = 1'b1
    } prg_mode_e;

    // Register targeted by a CPU write after partial address decode
    typedef enum logic [1:0] {
        TGT_NONE     = 2'd0,
        TGT_SELECT   = 2'd1,
        TGT_BANKDATA = 2'd2,
        TGT_RAMCTL   = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic enable;
        logic protect;
    } ram_ctl_t;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

endpackage

// File: rtl/prgmap_regs.sv
module prgmap_regs
    import prgmap_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        dec_addr,   // {a15, a14, a13, a0}
    input  logic [DATA_W-1:0] wdata,
    output prg_mode_e         mode,
    output logic [SEL_W-1:0]  sel,
    output logic [BANK_W-1:0] bank_a,
    output logic [BANK_W-1:0] bank_b,
    output ram_ctl_t          ram_ctl
);

    localparam int NUM_PRG = 2;
    localparam int SEL_FIRST_PRG = 6;

    wr_tgt_e            tgt;
    prg_mode_e          mode_q, mode_d;
    logic [SEL_W-1:0]   sel_q;
    logic [BANK_W-1:0]  bank_q [NUM_PRG];
    ram_ctl_t           ctl_q;

    // Write decode on the address bits the map depends on
    always_comb begin
        unique case (dec_addr)
            4'b1000: tgt = TGT_SELECT;
            4'b1001: tgt = TGT_BANKDATA;
            4'b1011: tgt = TGT_RAMCTL;
            default: tgt = TGT_NONE;
        endcase
    end

    // Next mode state
    always_comb begin
        mode_d = mode_q;
        if (wr && tgt == TGT_SELECT) begin
            unique case (wdata[6])
                1'b0: mode_d = MODE_LOW;
                1'b1: mode_d = MODE_HIGH;
            endcase
        end
    end

    // State register: mode and select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LOW;
            sel_q  <= '0;
        end else begin
            mode_q <= mode_d;
            if (wr && tgt == TGT_SELECT)
                sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Program bank registers
    for (genvar g = 0; g < NUM_PRG; g++) begin : g_prg
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (wr && tgt == TGT_BANKDATA && sel_q == SEL_W'(SEL_FIRST_PRG + g))
                bank_q[g] <= wdata[BANK_W-1:0];
        end
    end

    // Work-RAM control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.enable  <= 1'b1;
            ctl_q.protect <= 1'b0;
        end else if (wr && tgt == TGT_RAMCTL) begin
            ctl_q.enable  <= wdata[7];
            ctl_q.protect <= wdata[6];
        end
    end

    assign mode    = mode_q;
    assign sel     = sel_q;
    assign bank_a  = bank_q[0];
    assign bank_b  = bank_q[1];
    assign ram_ctl = ctl_q;

    p_sel_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_SELECT) |=> (sel == $past(wdata[2:0]) && mode == prg_mode_e'($past(wdata[6]))));

    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_BANKDATA && sel < SEL_W'(SEL_FIRST_PRG)) |=> ($stable(bank_a) && $stable(bank_b)));

    p_ramctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_RAMCTL) |=> (ram_ctl.enable == $past(wdata[7]) && ram_ctl.protect == $past(wdata[6])));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || tgt == TGT_NONE) |=> ($stable(mode) && $stable(sel) && $stable(bank_a) && $stable(bank_b) && $stable(ram_ctl)));

endmodule

// File: rtl/prgmap_addr.sv
module prgmap_addr
    import prgmap_pkg::*;
#(
    parameter int BANK_W = 6,
    parameter int OFS_W  = 13
) (
    input  logic [OFS_W+1:0]       cpu_addr,
    input  prg_mode_e              mode,
    input  logic [BANK_W-1:0]      bank_a,
    input  logic [BANK_W-1:0]      bank_b,
    output logic [BANK_W+OFS_W-1:0] rom_addr
);

    localparam logic [BANK_W-1:0] BANK_LAST   = '1;
    localparam logic [BANK_W-1:0] BANK_SECOND = BANK_LAST - 1'b1;

    logic [BANK_W-1:0] bank;

    always_comb begin
        unique case (cpu_addr[OFS_W+1:OFS_W])
            2'd0:    bank = (mode == MODE_HIGH) ? BANK_SECOND : bank_a;
            2'd1:    bank = bank_b;
            2'd2:    bank = (mode == MODE_HIGH) ? bank_a : BANK_SECOND;
            default: bank = BANK_LAST;
        endcase
    end

    assign rom_addr = {bank, cpu_addr[OFS_W-1:0]};

endmodule

// File: rtl/prgmap_ram_gate.sv
module prgmap_ram_gate
    import prgmap_pkg::*;
(
    input  logic     [2:0] addr_hi,
    input  logic           wr,
    input  ram_ctl_t       ctl,
    output logic           rd_en,
    output logic           wr_en
);

    logic in_ram;

    assign in_ram = (addr_hi == 3'b011);
    assign rd_en  = in_ram && ctl.enable;
    assign wr_en  = in_ram && wr && ctl.enable && !ctl.protect;

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prgmap_pkg::*;
#(
    parameter int BANK_W = 6,
    parameter int OFS_W  = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    cpu_wr,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    output logic [OFS_W-1:0]        ram_addr,
    output logic                    ram_rd_en,
    output logic                    ram_wr_en
);

    localparam int ROM_AW = BANK_W + OFS_W;

    prg_mode_e          mode;
    logic [SEL_W-1:0]   sel;
    logic [BANK_W-1:0]  bank_a, bank_b;
    ram_ctl_t           ram_ctl;

    prgmap_regs #(.BANK_W(BANK_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cpu_wr),
        .dec_addr ({cpu_addr[15:13], cpu_addr[0]}),
        .wdata    (cpu_wdata),
        .mode     (mode),
        .sel      (sel),
        .bank_a   (bank_a),
        .bank_b   (bank_b),
        .ram_ctl  (ram_ctl)
    );

    prgmap_addr #(.BANK_W(BANK_W), .OFS_W(OFS_W)) addr_i (
        .cpu_addr (cpu_addr[OFS_W+1:0]),
        .mode     (mode),
        .bank_a   (bank_a),
        .bank_b   (bank_b),
        .rom_addr (rom_addr)
    );

    prgmap_ram_gate ram_i (
        .addr_hi (cpu_addr[15:13]),
        .wr      (cpu_wr),
        .ctl     (ram_ctl),
        .rd_en   (ram_rd_en),
        .wr_en   (ram_wr_en)
    );

    assign ram_addr = cpu_addr[OFS_W-1:0];

    p_win3_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'd3) |-> (rom_addr[ROM_AW-1:OFS_W] == {BANK_W{1'b1}}));

    p_win1_regb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'd1) |-> (rom_addr[ROM_AW-1:OFS_W] == bank_b));

    p_swap_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIGH && cpu_addr[14:13] == 2'd0) |-> (rom_addr[ROM_AW-1:OFS_W] == {{(BANK_W-1){1'b1}}, 1'b0}));

    p_low_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOW && cpu_addr[14:13] == 2'd2) |-> (rom_addr[ROM_AW-1:OFS_W] == {{(BANK_W-1){1'b1}}, 1'b0}));

    p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> (cpu_addr[15:13] == 3'b011 && ram_ctl.enable));

    p_wr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (cpu_wr && ram_rd_en && !ram_ctl.protect));

endmodule

// File: tb/prg_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb_top;

    localparam real HALF = 2.5;

    typedef struct {
        logic [18:0] rom;
        logic        rd;
        logic        wr;
        logic [12:0] ram;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [18:0] rom_addr;
    logic [12:0] ram_addr;
    logic        ram_rd_en, ram_wr_en;

    int errors = 0;
    int checks = 0;
    exp_item_t q[$];

    // reference state, kept from the requirements
    logic       m_mode = 1'b0;
    logic [2:0] m_sel = '0;
    logic [5:0] m_a = '0, m_b = '0;
    logic       m_en = 1'b1, m_wp = 1'b0;

    always #(HALF) clk = ~clk;

    prg_bank_mapper dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_rd_en (ram_rd_en),
        .ram_wr_en (ram_wr_en)
    );

    function automatic logic [18:0] m_rom(logic [15:0] a);
        logic [5:0] b;
        case (a[14:13])
            2'd0:    b = m_mode ? 6'h3E : m_a;
            2'd1:    b = m_b;
            2'd2:    b = m_mode ? m_a : 6'h3E;
            default: b = 6'h3F;
        endcase
        return {b, a[12:0]};
    endfunction

    // driver: drive one cycle, push what the outputs must be in it
    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w, input string tag);
        exp_item_t it;
        logic in_ram;
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = w;
        in_ram = (a[15:13] == 3'b011);
        it.rom = m_rom(a);
        it.rd  = in_ram && m_en;
        it.wr  = w && in_ram && m_en && !m_wp;
        it.ram = a[12:0];
        it.tag = tag;
        q.push_back(it);
        if (w) begin
            case (a & 16'hE001)
                16'h8000: begin m_mode = d[6]; m_sel = d[2:0]; end
                16'h8001: begin
                    if (m_sel == 3'd6) m_a = d[5:0];
                    if (m_sel == 3'd7) m_b = d[5:0];
                end
                16'hA001: begin m_en = d[7]; m_wp = d[6]; end
                default: ;
            endcase
        end
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        cyc(a, 8'h00, 1'b0, tag);
    endtask

    // monitor: compare after the inputs settle, away from the edge
    always begin
        exp_item_t it;
        @(negedge clk);
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks += 4;
            if (rom_addr !== it.rom) begin
                errors++;
                $display("FAIL %s rom_addr addr=%h actual=%h expected=%h", it.tag, cpu_addr, rom_addr, it.rom);
            end
            if (ram_rd_en !== it.rd) begin
                errors++;
                $display("FAIL %s ram_rd_en addr=%h actual=%b expected=%b", it.tag, cpu_addr, ram_rd_en, it.rd);
            end
            if (ram_wr_en !== it.wr) begin
                errors++;
                $display("FAIL %s ram_wr_en addr=%h actual=%b expected=%b", it.tag, cpu_addr, ram_wr_en, it.wr);
            end
            if (ram_addr !== it.ram) begin
                errors++;
                $display("FAIL %s ram_addr actual=%h expected=%h", it.tag, ram_addr, it.ram);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through every window and the RAM range
        probe(16'h8000, "R1");
        probe(16'hA123, "R1");
        probe(16'hC000, "R1");
        probe(16'hE000, "R1");
        probe(16'h6000, "R1");
        // R7: load bank A with 0xFF, masked to 0x3F
        cyc(16'h8000, 8'h06, 1'b1, "R6");
        cyc(16'h8001, 8'hFF, 1'b1, "R7");
        cyc(16'h8000, 8'h07, 1'b1, "R6");
        cyc(16'h8001, 8'h45, 1'b1, "R7");
        // R2, R3, R5: mode low mapping with offsets
        probe(16'h8ABC, "R3");
        probe(16'h9FFF, "R2");
        probe(16'hB456, "R5");
        probe(16'hD001, "R3");
        probe(16'hFFFF, "R5");
        // R6: mirror address selects mode high; R4 swap
        cyc(16'h9FFE, 8'h46, 1'b1, "R6");
        probe(16'h8010, "R4");
        probe(16'hC777, "R4");
        probe(16'hA000, "R5");
        probe(16'hE555, "R5");
        // R7: select 3 bank data leaves program banks
        cyc(16'h8000, 8'h43, 1'b1, "R6");
        cyc(16'h8001, 8'h11, 1'b1, "R7");
        probe(16'hC000, "R7");
        probe(16'hA000, "R7");
        // R11: strobe low and other decoded addresses change nothing
        cyc(16'h8000, 8'h06, 1'b0, "R11");
        probe(16'h8000, "R11");
        cyc(16'hA000, 8'h00, 1'b1, "R11");
        cyc(16'hC001, 8'h00, 1'b1, "R11");
        cyc(16'hE000, 8'h00, 1'b1, "R11");
        cyc(16'h6001, 8'h00, 1'b1, "R11");
        probe(16'h7000, "R11");
        probe(16'hC000, "R11");
        // R9, R10: RAM enabled and writable
        cyc(16'h6010, 8'h5A, 1'b1, "R10");
        probe(16'h5FFF, "R9");
        probe(16'h8000, "R9");
        // R8: protect, then disable, then re-enable
        cyc(16'hA001, 8'hC0, 1'b1, "R8");
        cyc(16'h7FFF, 8'h33, 1'b1, "R10");
        probe(16'h6200, "R9");
        cyc(16'hBFFF, 8'h00, 1'b1, "R8");
        cyc(16'h7FFF, 8'h33, 1'b1, "R10");
        probe(16'h6200, "R9");
        cyc(16'hA001, 8'h80, 1'b1, "R8");
        cyc(16'h6ABC, 8'h33, 1'b1, "R10");
        // R6: back to mode low
        cyc(16'h8000, 8'h00, 1'b1, "R6");
        probe(16'h8000, "R3");
        probe(16'hC000, "R3");
        @(negedge clk);
        cpu_wr = 1'b0;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule